// File: doc/BRIEF.md
# Banked Memory Map Decoder

This block sits between the CPU of an 8-bit handheld console and its memories and peripherals. It takes the CPU's 16-bit address and picks one target for each access. The targets are the fixed and switchable ROM windows, video RAM, cartridge RAM or the clock registers, the two halves of work RAM, the sprite attribute table, the I/O space, high RAM, and the interrupt-enable register. Reads are combinational: the byte from the chosen target, or 0xFF, appears on `cpu_rdata` in the same cycle as the address. Writes commit on the rising clock edge while `cpu_we` is high. Each target gets its own one-cycle write strobe.

The block owns three pieces of state:
- the work-RAM bank register, found in I/O space at 0xFF70;
- the current switchable ROM bank, which the external bank controller loads;
- high RAM and the interrupt-enable byte.

A store into the ROM window does not change ROM. It is passed to the bank controller as an address/data pair. The ROM image, the controller's own logic, video RAM, the sprite table and the other I/O registers sit outside the block and are reached through plain address, strobe and read-data ports.

Top module: `mmd_top`

## Requirements
- R1: Addresses 0x0000–0x3FFF read `rom_rdata`, with `rom_addr` = {all-zero bank field, address[13:0]}.
- R2: Addresses 0x4000–0x7FFF read `rom_rdata`, with `rom_addr` = {`rom_bank`, address[13:0]}. `rom_bank` is 1 after reset and takes `mbc_bank_val` on any clock edge where `mbc_bank_load` is high.
- R3: A write to 0x0000–0x7FFF raises only `mbc_we`, with `mbc_addr` = address[14:0] and `mbc_wdata` = the CPU data.
- R4: Addresses 0x8000–0x9FFF read `vram_rdata` and strobe `vram_we` on writes, with `vram_addr` = address[12:0].
- R5: In 0xA000–0xBFFF, the clock registers win when `clk_reg_en` is high (`clkreg_rdata`/`clkreg_we`). Otherwise cartridge RAM is used when `cart_ram_en` is high (`cram_rdata`/`cram_we`, `cram_addr` = address[12:0]). Otherwise reads give 0xFF and writes raise no strobe.
- R6: 0xC000–0xCFFF and its echo 0xE000–0xEFFF use `wram_addr` = {3'd0, address[11:0]}. 0xD000–0xDFFF and its echo 0xF000–0xFDFF use `wram_addr` = {current bank, address[11:0]}. All four read `wram_rdata` and strobe `wram_we`.
- R7: A write to 0xFF70 stores data[2:0] as the work-RAM bank, with 0 stored as 1. The bank is 1 after reset. A read of 0xFF70 returns {5'b11111, bank}, and `io_we` stays low for that address.
- R8: 0xFE00–0xFE9F reaches the sprite table (`oam_addr` = address[7:0]) only while `video_mode` is 0 or 1. In modes 2 and 3, reads give 0xFF and `oam_we` stays low.
- R9: 0xFEA0–0xFEFF reads 0xFF and writes there raise no strobe.
- R10: 0xFF00–0xFF7F, except 0xFF70, reads `io_rdata` and strobes `io_we`, with `io_addr` = address[6:0].
- R11: 0xFF80–0xFFFE is a 127-byte high RAM held inside the block. A byte written there reads back unchanged.
- R12: 0xFFFF is the interrupt-enable register. It is 0 after reset, takes the written byte, reads back, and drives `ie_mask`.
- R13: At most one external write strobe is high in any cycle, and none is high while `cpu_we` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_we | input | 1 | CPU write enable |
| cpu_rdata | output | 8 | Read data for the current address |
| rom_addr | output | 22 | ROM byte address: bank and offset |
| rom_rdata | input | 8 | ROM read data |
| mbc_we | output | 1 | Bank-controller write strobe |
| mbc_addr | output | 15 | Bank-controller write address |
| mbc_wdata | output | 8 | Bank-controller write data |
| mbc_bank_load | input | 1 | Controller loads a new ROM bank |
| mbc_bank_val | input | 8 | New ROM bank number |
| rom_bank | output | 8 | Current switchable ROM bank |
| vram_addr | output | 13 | Video RAM offset |
| vram_we | output | 1 | Video RAM write strobe |
| vram_rdata | input | 8 | Video RAM read data |
| cart_ram_en | input | 1 | Cartridge RAM enabled |
| clk_reg_en | input | 1 | Clock-register window enabled |
| cram_addr | output | 13 | Cartridge RAM / clock offset |
| cram_we | output | 1 | Cartridge RAM write strobe |
| cram_rdata | input | 8 | Cartridge RAM read data |
| clkreg_we | output | 1 | Clock-register write strobe |
| clkreg_rdata | input | 8 | Selected clock-register data |
| wram_addr | output | 15 | Work RAM address: bank and offset |
| wram_we | output | 1 | Work RAM write strobe |
| wram_rdata | input | 8 | Work RAM read data |
| video_mode | input | 2 | Current video mode |
| oam_addr | output | 8 | Sprite table offset |
| oam_we | output | 1 | Sprite table write strobe |
| oam_rdata | input | 8 | Sprite table read data |
| io_addr | output | 7 | I/O register offset |
| io_we | output | 1 | I/O write strobe |
| io_rdata | input | 8 | I/O read data |
| periph_wdata | output | 8 | Write data to all peripherals |
| ie_mask | output | 8 | Interrupt-enable register value |

## Verification
If the work-RAM bank register is wrong, the error shows on `wram_addr[14:12]` in the very cycle any address in 0xD000–0xDFFF or 0xF000–0xFDFF is presented. It also shows on the read of 0xFF70. Either way it appears with no latency, because the register feeds combinational paths only. A wrong ROM bank shows the same way on `rom_addr` for any address in 0x4000–0x7FFF. A fault in the region decode shows on the cycle of the access itself: a strobe on the wrong target, two strobes at once, or 0xFF where data was due. High RAM and the interrupt-enable byte expose damage on the first read after the write that should have set them.

// File: rtl/mmd_pkg.sv
package mmd_pkg;

  localparam int ADDR_W    = 16;
  localparam int DATA_W    = 8;
  localparam int ROM_OFF_W = 14;
  localparam int WBANK_W   = 3;

  typedef enum logic [3:0] {
    RG_ROM0, RG_ROMX, RG_VRAM, RG_CART, RG_WRAM0, RG_WRAMX,
    RG_OAM, RG_VOID, RG_IO, RG_HRAM, RG_IE
  } region_e;

  // Address to target region; the upper bits pick the window.
  function automatic region_e decode_region(input logic [ADDR_W-1:0] a);
    if (a[15:14] == 2'b00) return RG_ROM0;
    if (a[15:14] == 2'b01) return RG_ROMX;
    if (a[15:13] == 3'b100) return RG_VRAM;
    if (a[15:13] == 3'b101) return RG_CART;
    if (a[15:9] != 7'h7F) return a[12] ? RG_WRAMX : RG_WRAM0;
    if (a[8] == 1'b0) return (a[7:0] < 8'hA0) ? RG_OAM : RG_VOID;
    if (a[7] == 1'b0) return RG_IO;
    if (a[6:0] == 7'h7F) return RG_IE;
    return RG_HRAM;
  endfunction

  // Bank select: zero is promoted to one.
  function automatic logic [WBANK_W-1:0] fold_bank(input logic [WBANK_W-1:0] v);
    return (v == '0) ? WBANK_W'(1) : v;
  endfunction

  // Sprite table reachable in modes 0 and 1 only.
  function automatic logic oam_open(input logic [1:0] mode);
    return mode[1] == 1'b0;
  endfunction

endpackage

// File: rtl/mmd_region_decode.sv
module mmd_region_decode
  import mmd_pkg::*;
#(
  parameter logic [15:0] BANK_REG_ADDR = 16'hFF70
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region,
  output logic              bank_hit
);
  always_comb begin
    region   = decode_region(addr);
    bank_hit = (addr == BANK_REG_ADDR);
  end
endmodule

// File: rtl/mmd_wram_bank.sv
module mmd_wram_bank
  import mmd_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [WBANK_W-1:0] wr_val,
  output logic [WBANK_W-1:0] bank
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     bank <= WBANK_W'(1);
    else if (wr_en) bank <= fold_bank(wr_val);
  end
endmodule

// File: rtl/mmd_rom_bank.sv
module mmd_rom_bank #(
  parameter int BANK_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BANK_W-1:0] val,
  output logic [BANK_W-1:0] bank
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    bank <= BANK_W'(1);
    else if (load) bank <= val;
  end
endmodule

// File: rtl/mmd_hram.sv
module mmd_hram #(
  parameter int DEPTH = 127,
  parameter int DW    = 8
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] idx,
  input  logic [DW-1:0]            wdata,
  output logic [DW-1:0]            rdata
);
  localparam int IDX_W = $clog2(DEPTH);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we && (32'(idx) < DEPTH)) mem[idx] <= wdata;
  end

  always_comb begin
    rdata = {DW{1'b1}};
    for (int i = 0; i < DEPTH; i++) begin
      if (idx == IDX_W'(i)) rdata = mem[i];
    end
  end
endmodule

// File: rtl/mmd_top.sv
module mmd_top
  import mmd_pkg::*;
#(
  parameter int          ROM_BANK_W    = 8,
  parameter int          HRAM_DEPTH    = 127,
  parameter logic [15:0] BANK_REG_ADDR = 16'hFF70
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [15:0]                   cpu_addr,
  input  logic [7:0]                    cpu_wdata,
  input  logic                          cpu_we,
  output logic [7:0]                    cpu_rdata,
  output logic [ROM_BANK_W+13:0]        rom_addr,
  input  logic [7:0]                    rom_rdata,
  output logic                          mbc_we,
  output logic [14:0]                   mbc_addr,
  output logic [7:0]                    mbc_wdata,
  input  logic                          mbc_bank_load,
  input  logic [ROM_BANK_W-1:0]         mbc_bank_val,
  output logic [ROM_BANK_W-1:0]         rom_bank,
  output logic [12:0]                   vram_addr,
  output logic                          vram_we,
  input  logic [7:0]                    vram_rdata,
  input  logic                          cart_ram_en,
  input  logic                          clk_reg_en,
  output logic [12:0]                   cram_addr,
  output logic                          cram_we,
  input  logic [7:0]                    cram_rdata,
  output logic                          clkreg_we,
  input  logic [7:0]                    clkreg_rdata,
  output logic [14:0]                   wram_addr,
  output logic                          wram_we,
  input  logic [7:0]                    wram_rdata,
  input  logic [1:0]                    video_mode,
  output logic [7:0]                    oam_addr,
  output logic                          oam_we,
  input  logic [7:0]                    oam_rdata,
  output logic [6:0]                    io_addr,
  output logic                          io_we,
  input  logic [7:0]                    io_rdata,
  output logic [7:0]                    periph_wdata,
  output logic [7:0]                    ie_mask
);
  localparam int HIDX_W = $clog2(HRAM_DEPTH);

  region_e              region;
  logic                 bank_hit;
  logic [WBANK_W-1:0]   wbank_q;
  logic                 bank_wr_evt;
  logic                 hram_wr_evt;
  logic                 ie_wr_evt;
  logic [7:0]           hram_rdata;
  logic [7:0]           ie_q;
  logic                 oam_gate;

  mmd_region_decode #(.BANK_REG_ADDR(BANK_REG_ADDR)) u_dec (
    .addr(cpu_addr), .region(region), .bank_hit(bank_hit)
  );

  assign bank_wr_evt = cpu_we && (region == RG_IO) && bank_hit;
  assign hram_wr_evt = cpu_we && (region == RG_HRAM);
  assign ie_wr_evt   = cpu_we && (region == RG_IE);
  assign oam_gate    = oam_open(video_mode);

  mmd_wram_bank u_wbank (
    .clk(clk), .rst_n(rst_n), .wr_en(bank_wr_evt),
    .wr_val(cpu_wdata[WBANK_W-1:0]), .bank(wbank_q)
  );

  mmd_rom_bank #(.BANK_W(ROM_BANK_W)) u_rbank (
    .clk(clk), .rst_n(rst_n), .load(mbc_bank_load),
    .val(mbc_bank_val), .bank(rom_bank)
  );

  mmd_hram #(.DEPTH(HRAM_DEPTH), .DW(8)) u_hram (
    .clk(clk), .we(hram_wr_evt), .idx(cpu_addr[HIDX_W-1:0]),
    .wdata(cpu_wdata), .rdata(hram_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ie_q <= 8'h00;
    else if (ie_wr_evt) ie_q <= cpu_wdata;
  end
  assign ie_mask = ie_q;

  // Addresses toward the targets
  always_comb begin
    rom_addr     = {(region == RG_ROMX) ? rom_bank : {ROM_BANK_W{1'b0}},
                    cpu_addr[ROM_OFF_W-1:0]};
    wram_addr    = {(region == RG_WRAMX) ? wbank_q : {WBANK_W{1'b0}},
                    cpu_addr[11:0]};
    vram_addr    = cpu_addr[12:0];
    cram_addr    = cpu_addr[12:0];
    oam_addr     = cpu_addr[7:0];
    io_addr      = cpu_addr[6:0];
    mbc_addr     = cpu_addr[14:0];
    mbc_wdata    = cpu_wdata;
    periph_wdata = cpu_wdata;
  end

  // Write strobes, one per target
  always_comb begin
    mbc_we    = 1'b0;
    vram_we   = 1'b0;
    cram_we   = 1'b0;
    clkreg_we = 1'b0;
    wram_we   = 1'b0;
    oam_we    = 1'b0;
    io_we     = 1'b0;
    if (cpu_we) begin
      case (region)
        RG_ROM0, RG_ROMX:   mbc_we  = 1'b1;
        RG_VRAM:            vram_we = 1'b1;
        RG_CART: begin
          if (clk_reg_en)       clkreg_we = 1'b1;
          else if (cart_ram_en) cram_we   = 1'b1;
        end
        RG_WRAM0, RG_WRAMX: wram_we = 1'b1;
        RG_OAM:             oam_we  = oam_gate;
        RG_IO:              io_we   = !bank_hit;
        default: ;
      endcase
    end
  end

  // Read multiplexer
  always_comb begin
    cpu_rdata = 8'hFF;
    case (region)
      RG_ROM0, RG_ROMX:   cpu_rdata = rom_rdata;
      RG_VRAM:            cpu_rdata = vram_rdata;
      RG_CART: begin
        if (clk_reg_en)       cpu_rdata = clkreg_rdata;
        else if (cart_ram_en) cpu_rdata = cram_rdata;
      end
      RG_WRAM0, RG_WRAMX: cpu_rdata = wram_rdata;
      RG_OAM:             if (oam_gate) cpu_rdata = oam_rdata;
      RG_IO:              cpu_rdata = bank_hit ? {{(8-WBANK_W){1'b1}}, wbank_q} : io_rdata;
      RG_HRAM:            cpu_rdata = hram_rdata;
      RG_IE:              cpu_rdata = ie_q;
      default:            cpu_rdata = 8'hFF;
    endcase
  end

endmodule

// File: rtl/mmd_chk.sv
module mmd_chk
  import mmd_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic [15:0]        cpu_addr,
  input logic [7:0]         cpu_wdata,
  input logic               cpu_we,
  input logic [7:0]         cpu_rdata,
  input logic [1:0]         video_mode,
  input logic               mbc_we,
  input logic               vram_we,
  input logic               cram_we,
  input logic               clkreg_we,
  input logic               wram_we,
  input logic               oam_we,
  input logic               io_we,
  input logic [14:0]        wram_addr,
  input logic [7:0]         ie_mask,
  input region_e            region,
  input logic               bank_wr_evt,
  input logic [WBANK_W-1:0] wbank_q
);
  logic [6:0] strobes;
  assign strobes = {mbc_we, vram_we, cram_we, clkreg_we, wram_we, oam_we, io_we};

  // R13
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strobes));

  // R13
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_we |-> (strobes == 7'd0));

  // R3
  mbc_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mbc_we |-> (cpu_addr[15] == 1'b0));

  // R8
  oam_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oam_we |-> (video_mode[1] == 1'b0));

  // R6
  wram_bank_nz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (region == RG_WRAMX) |-> (wram_addr[14:12] != 3'd0));

  // R7
  bank_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bank_wr_evt |=> (($past(cpu_wdata[2:0]) == 3'd0) ? (wbank_q == 3'd1)
                                                     : (wbank_q == $past(cpu_wdata[2:0]))));

  // R9
  void_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr >= 16'hFEA0 && cpu_addr <= 16'hFEFF) |-> (cpu_rdata == 8'hFF));

  // R12
  ie_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_we && cpu_addr == 16'hFFFF) |=> (ie_mask == $past(cpu_wdata)));
endmodule

bind mmd_top mmd_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
  .cpu_we(cpu_we), .cpu_rdata(cpu_rdata), .video_mode(video_mode),
  .mbc_we(mbc_we), .vram_we(vram_we), .cram_we(cram_we), .clkreg_we(clkreg_we),
  .wram_we(wram_we), .oam_we(oam_we), .io_we(io_we), .wram_addr(wram_addr),
  .ie_mask(ie_mask), .region(region), .bank_wr_evt(bank_wr_evt), .wbank_q(wbank_q)
);

// File: tb/sim_mmd_top.sv
`timescale 1ns/1ps
module sim_mmd_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_we = 1'b0;
  logic [7:0]  cpu_rdata;
  logic [21:0] rom_addr;
  logic        mbc_we;
  logic [14:0] mbc_addr;
  logic [7:0]  mbc_wdata;
  logic        mbc_bank_load = 1'b0;
  logic [7:0]  mbc_bank_val = '0;
  logic [7:0]  rom_bank;
  logic [12:0] vram_addr, cram_addr;
  logic        vram_we, cram_we, clkreg_we, wram_we, oam_we, io_we;
  logic        cart_ram_en = 1'b0, clk_reg_en = 1'b0;
  logic [14:0] wram_addr;
  logic [1:0]  video_mode = 2'd0;
  logic [7:0]  oam_addr;
  logic [6:0]  io_addr;
  logic [7:0]  periph_wdata, ie_mask;

  mmd_top u0 (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_we(cpu_we), .cpu_rdata(cpu_rdata), .rom_addr(rom_addr),
    .rom_rdata(8'h11), .mbc_we(mbc_we), .mbc_addr(mbc_addr),
    .mbc_wdata(mbc_wdata), .mbc_bank_load(mbc_bank_load),
    .mbc_bank_val(mbc_bank_val), .rom_bank(rom_bank), .vram_addr(vram_addr),
    .vram_we(vram_we), .vram_rdata(8'h22), .cart_ram_en(cart_ram_en),
    .clk_reg_en(clk_reg_en), .cram_addr(cram_addr), .cram_we(cram_we),
    .cram_rdata(8'h33), .clkreg_we(clkreg_we), .clkreg_rdata(8'h44),
    .wram_addr(wram_addr), .wram_we(wram_we), .wram_rdata(8'h55),
    .video_mode(video_mode), .oam_addr(oam_addr), .oam_we(oam_we),
    .oam_rdata(8'h66), .io_addr(io_addr), .io_we(io_we), .io_rdata(8'h77),
    .periph_wdata(periph_wdata), .ie_mask(ie_mask)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] strobes();
    return {mbc_we, vram_we, cram_we, clkreg_we, wram_we, oam_we, io_we};
  endfunction

  // Requirement tag for a read vector, from the address map in the brief
  function automatic string req_of(input logic [15:0] a);
    if (a < 16'h4000) return "R1";
    if (a < 16'h8000) return "R2";
    if (a < 16'hA000) return "R4";
    if (a < 16'hC000) return "R5";
    if (a < 16'hFE00) return "R6";
    if (a < 16'hFEA0) return "R8";
    if (a < 16'hFF00) return "R9";
    if (a < 16'hFF80) return "R10";
    if (a == 16'hFFFF) return "R12";
    return "R11";
  endfunction

  // {addr[16], mode[2], cart_ram_en, clk_reg_en, expected[8]}
  localparam int NV = 22;
  localparam logic [27:0] VEC [NV] = '{
    {16'h0000, 2'd0, 1'b0, 1'b0, 8'h11},   // R1
    {16'h3FFF, 2'd0, 1'b0, 1'b0, 8'h11},   // R1
    {16'h4000, 2'd0, 1'b0, 1'b0, 8'h11},   // R2
    {16'h8000, 2'd0, 1'b0, 1'b0, 8'h22},   // R4
    {16'h9FFF, 2'd0, 1'b0, 1'b0, 8'h22},   // R4
    {16'hA000, 2'd0, 1'b0, 1'b0, 8'hFF},   // R5 nothing enabled
    {16'hA123, 2'd0, 1'b1, 1'b0, 8'h33},   // R5 cartridge RAM
    {16'hA123, 2'd0, 1'b1, 1'b1, 8'h44},   // R5 clock wins
    {16'hB000, 2'd0, 1'b0, 1'b1, 8'h44},   // R5
    {16'hC000, 2'd0, 1'b0, 1'b0, 8'h55},   // R6
    {16'hE500, 2'd0, 1'b0, 1'b0, 8'h55},   // R6 echo
    {16'hDFFF, 2'd0, 1'b0, 1'b0, 8'h55},   // R6
    {16'hFDFF, 2'd0, 1'b0, 1'b0, 8'h55},   // R6 echo top
    {16'hFE00, 2'd0, 1'b0, 1'b0, 8'h66},   // R8
    {16'hFE9F, 2'd1, 1'b0, 1'b0, 8'h66},   // R8
    {16'hFE10, 2'd2, 1'b0, 1'b0, 8'hFF},   // R8 blocked
    {16'hFE10, 2'd3, 1'b0, 1'b0, 8'hFF},   // R8 blocked
    {16'hFEA0, 2'd0, 1'b0, 1'b0, 8'hFF},   // R9
    {16'hFEFF, 2'd0, 1'b0, 1'b0, 8'hFF},   // R9
    {16'hFF00, 2'd0, 1'b0, 1'b0, 8'h77},   // R10
    {16'hFF7F, 2'd0, 1'b0, 1'b0, 8'h77},   // R10
    {16'hFFFF, 2'd0, 1'b0, 1'b0, 8'h00}    // R12 reset value
  };

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_we = 1'b1;
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Reset state
    check("R2 reset bank", rom_bank, 8'd1);
    check("R12 reset ie", ie_mask, 8'd0);
    cpu_addr = 16'hFF70; #2;
    check("R7 reset wbank", cpu_rdata, 8'hF9);

    // Vector walk: reads, with no strobe since cpu_we is low
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      cpu_addr = VEC[i][27:12]; video_mode = VEC[i][11:10];
      cart_ram_en = VEC[i][9]; clk_reg_en = VEC[i][8];
      #2;
      check(req_of(cpu_addr), cpu_rdata, VEC[i][7:0]);
      check("R13 idle", strobes(), 7'd0);
    end
    cart_ram_en = 1'b0; clk_reg_en = 1'b0; video_mode = 2'd0;

    // ROM addressing
    @(negedge clk); cpu_addr = 16'h1234; #2;
    check("R1 rom_addr", rom_addr, {8'd0, 14'h1234});
    cpu_addr = 16'h5678; #2;
    check("R2 rom_addr", rom_addr, {8'd1, 14'h1678});
    @(negedge clk); mbc_bank_load = 1'b1; mbc_bank_val = 8'h2A;
    @(negedge clk); mbc_bank_load = 1'b0; cpu_addr = 16'h4001; #2;
    check("R2 loaded bank", rom_addr, {8'h2A, 14'h0001});

    // Bank-controller forwarding
    @(negedge clk); cpu_addr = 16'h2000; cpu_wdata = 8'h05; cpu_we = 1'b1; #2;
    check("R3 strobe", strobes(), 7'b1000000);
    check("R3 addr", mbc_addr, 15'h2000);
    check("R3 data", mbc_wdata, 8'h05);
    cpu_addr = 16'h7FFF; #2;
    check("R3 top strobe", strobes(), 7'b1000000);
    @(negedge clk); cpu_we = 1'b0;

    // VRAM and I/O addressing
    cpu_addr = 16'h9ABC; #2; check("R4 vram_addr", vram_addr, 13'h1ABC);
    cpu_addr = 16'hFF45; #2; check("R10 io_addr", io_addr, 7'h45);
    cpu_we = 1'b1; #2; check("R10 io_we", strobes(), 7'b0000001);
    @(negedge clk); cpu_we = 1'b0;

    // Work-RAM bank register
    @(negedge clk); cpu_addr = 16'hFF70; cpu_wdata = 8'h0D; cpu_we = 1'b1; #2;
    check("R7 no io_we", strobes(), 7'd0);
    @(negedge clk); cpu_we = 1'b0; #2;
    check("R7 bank 5", cpu_rdata, 8'hFD);
    cpu_addr = 16'hD123; #2; check("R6 bank window", wram_addr, {3'd5, 12'h123});
    cpu_addr = 16'hF456; #2; check("R6 echo bank", wram_addr, {3'd5, 12'h456});
    cpu_addr = 16'hE789; #2; check("R6 echo fixed", wram_addr, {3'd0, 12'h789});
    wr(16'hFF70, 8'h00);
    cpu_addr = 16'hFF70; #2; check("R7 zero to one", cpu_rdata, 8'hF9);
    cpu_addr = 16'hD000; #2; check("R6 bank one", wram_addr, {3'd1, 12'h000});
    wr(16'hFF70, 8'h08);
    cpu_addr = 16'hFF70; #2; check("R7 low bits only", cpu_rdata, 8'hF9);
    wr(16'hFF70, 8'hF7);
    cpu_addr = 16'hFF70; #2; check("R7 bank 7", cpu_rdata, 8'hFF);

    // Sprite table gating
    @(negedge clk); cpu_addr = 16'hFE20; cpu_we = 1'b1; video_mode = 2'd2; #2;
    check("R8 blocked write", strobes(), 7'd0);
    video_mode = 2'd0; #2;
    check("R8 open write", strobes(), 7'b0000010);
    check("R8 oam_addr", oam_addr, 8'h20);
    // Unusable area
    cpu_addr = 16'hFEC0; #2;
    check("R9 dropped write", strobes(), 7'd0);
    // Cartridge window writes
    cpu_addr = 16'hA010; clk_reg_en = 1'b1; cart_ram_en = 1'b1; #2;
    check("R5 clock write", strobes(), 7'b0001000);
    clk_reg_en = 1'b0; #2;
    check("R5 ram write", strobes(), 7'b0010000);
    check("R5 cram_addr", cram_addr, 13'h0010);
    cart_ram_en = 1'b0; #2;
    check("R5 gated write", strobes(), 7'd0);
    @(negedge clk); cpu_we = 1'b0;

    // High RAM and interrupt enable
    wr(16'hFF80, 8'hA5);
    wr(16'hFFFE, 8'h5A);
    wr(16'hFFFF, 8'h1F);
    cpu_addr = 16'hFF80; #2; check("R11 low byte", cpu_rdata, 8'hA5);
    cpu_addr = 16'hFFFE; #2; check("R11 high byte", cpu_rdata, 8'h5A);
    cpu_addr = 16'hFFFF; #2; check("R12 readback", cpu_rdata, 8'h1F);
    check("R12 ie_mask", ie_mask, 8'h1F);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule